// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a first-level (directory) entry and then a second-level (table) entry through a simple word-wide memory port. It checks the entry flags at each level and sets the accessed and dirty flags in memory when they need to change. The result goes back over a valid/ready response channel as either a physical address or a fault.

The linear address splits 10/10/12: the upper ten bits index the directory, the next ten bits index the table, and the low twelve bits are the byte offset inside a 4 KB page. The directory sits at a 4 KB-aligned frame held in a loadable base register. A translation-enable input, when low, makes the block pass the address straight through with no memory traffic.

A fault returns a three-bit code and latches the offending address into a fault-address output:

- code bit 0 is set for a protection violation and clear for a not-present entry;
- code bit 1 is set for a write;
- code bit 2 is set for a user-mode access.

Top module: `xlat_walker`

## Requirements
- R1: A walk issues at most one memory access at a time. It first reads the directory entry at base frame × 4096 + 4 × addr[31:22], then reads the table entry at (directory entry bits 31-12) × 4096 + 4 × addr[21:12].
- R2: A successful walk returns the physical address {table entry bits 31-12, addr[11:0]}. For example, linear 0x3E837B0A with a page frame of 0x0001B000 gives 0x0001BB0A.
- R3: If entry bit 0 (present) is clear at either level, the walk stops with a fault and error-code bit 0 = 0. No further memory access is made for that request.
- R4: A protection fault (error-code bit 0 = 1) is raised at either level in two cases: a write where entry bit 1 (writable) is 0, or a user access where entry bit 2 (user) is 0. An access that satisfies both bits does not fault.
- R5: Error-code bit 1 equals the request's write flag, and bit 2 equals the request's user flag.
- R6: On every fault, fault_addr holds the linear address of the faulting request.
- R7: When bit 5 (accessed) of a present, permitted entry is clear, the entry is written back with bit 5 set before the walk proceeds or responds. An entry whose bit 5 is already set is not written.
- R8: Bit 6 (dirty) of a table entry is set in the write-back only for a successful write access. It is never set for reads, for faults, or in directory entries.
- R9: With xlat_en low, an accepted request gives a response in the next cycle with rsp_paddr equal to the linear address, no fault and no memory access.
- R10: A pulse on base_load makes base_frame the directory frame for all later walks.
- R11: req_ready is high only when the block is idle. Once rsp_valid rises, rsp_valid, rsp_paddr, rsp_fault and rsp_fcode stay unchanged until rsp_ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| base_load | input | 1 | Load pulse for the directory base register |
| base_frame | input | 20 | Directory frame number (address bits 31-12) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fcode | output | 3 | Fault code: bit0 protection, bit1 write, bit2 user |
| fault_addr | output | 32 | Linear address of the latest fault |
| mem_req | output | 1 | Memory access strobe (one cycle) |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address, word aligned) |
| mem_wdata | output | 32 | Entry value to write |
| mem_rvalid | input | 1 | Memory completion; carries read data for reads |
| mem_rdata | input | 32 | Read data |

## Verification
The walk is driven with the worked address three times in a row. The first pass is a supervisor read with both accessed flags clear. The second is a write once the flags are set. The third repeats the write. Comparing the three access sequences separates the accessed write-back from the dirty write-back and shows that redundant writes are dropped.

Not-present entries are placed at each level in turn. Read-only and supervisor-only entries are each hit by the access that should pass and by the access that should fail. Together these separate the two fault kinds and confirm that the write and user bits of the error code follow the request, not the entry.

Two further runs cover the remaining paths. Pass-through requests and a base reload show that the directory address comes from the base register only when translation is on. Held-back responses show that the result stays stable while the consumer stalls.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITE    = 1;
  localparam int unsigned BIT_USER     = 2;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned BIT_DIRTY    = 6;
  localparam int unsigned FCODE_W      = 3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DIR_RD,
    S_DIR_WAIT,
    S_DIR_CHK,
    S_DIR_WB,
    S_DIR_WBW,
    S_TBL_RD,
    S_TBL_WAIT,
    S_TBL_CHK,
    S_TBL_WB,
    S_TBL_WBW,
    S_RESP
  } walk_state_e;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned FRAME_W = VA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [FRAME_W-1:0] page_frame,
  input  logic [VA_W-1:0]    vaddr,
  output logic [VA_W-1:0]    dir_entry_addr,
  output logic [VA_W-1:0]    tbl_entry_addr,
  output logic [VA_W-1:0]    phys_addr
);
  // word-sized entries: index scaled by four inside a 4 KB-aligned frame
  function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0]   idx);
    return {frame, {OFF_W{1'b0}}} + VA_W'({idx, 2'b00});
  endfunction

  function automatic logic [VA_W-1:0] join_frame(input logic [FRAME_W-1:0] frame,
                                                 input logic [OFF_W-1:0]   off);
    return {frame, off};
  endfunction

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0] page_off;

  assign dir_idx  = vaddr[VA_W-1 -: IDX_W];
  assign tbl_idx  = vaddr[OFF_W +: IDX_W];
  assign page_off = vaddr[OFF_W-1:0];

  assign dir_entry_addr = entry_addr(dir_frame, dir_idx);
  assign tbl_entry_addr = entry_addr(tbl_frame, tbl_idx);
  assign phys_addr      = join_frame(page_frame, page_off);
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  input  logic               is_user,
  input  logic               is_leaf,
  output logic               not_present,
  output logic               prot_viol,
  output logic [ENTRY_W-1:0] upd_entry,
  output logic               need_wb
);
  logic deny_write;
  logic deny_user;
  logic [ENTRY_W-1:0] set_mask;

  assign deny_write  = is_write & ~entry[BIT_WRITE];
  assign deny_user   = is_user  & ~entry[BIT_USER];
  assign not_present = ~entry[BIT_PRESENT];
  assign prot_viol   = entry[BIT_PRESENT] & (deny_write | deny_user);

  always_comb begin
    set_mask = '0;
    set_mask[BIT_ACCESSED] = 1'b1;
    set_mask[BIT_DIRTY]    = is_leaf & is_write;
  end

  assign upd_entry = entry | set_mask;
  assign need_wb   = (upd_entry != entry);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned FRAME_W = VA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xlat_en,
  input  logic               base_load,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic [FCODE_W-1:0] rsp_fcode,
  output logic [VA_W-1:0]    fault_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_rvalid,
  input  logic [VA_W-1:0]    mem_rdata
);
  walk_state_e state_q;

  logic [FRAME_W-1:0] base_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic               usr_q;
  logic [VA_W-1:0]    pde_q;
  logic [VA_W-1:0]    pte_q;
  logic [VA_W-1:0]    rsp_paddr_q;
  logic               rsp_fault_q;
  logic [FCODE_W-1:0] rsp_code_q;
  logic [VA_W-1:0]    fault_addr_q;

  // named internal events
  logic               is_leaf;
  logic               in_check;
  logic               req_fire;
  logic               ev_np;
  logic               ev_prot;
  logic               ev_fault;
  logic               need_wb;
  logic [VA_W-1:0]    upd_entry;
  logic [VA_W-1:0]    chk_entry;
  logic [VA_W-1:0]    dir_entry_addr;
  logic [VA_W-1:0]    tbl_entry_addr;
  logic [VA_W-1:0]    phys_addr;

  assign is_leaf   = (state_q inside {S_TBL_RD, S_TBL_WAIT, S_TBL_CHK, S_TBL_WB, S_TBL_WBW});
  assign in_check  = (state_q == S_DIR_CHK) || (state_q == S_TBL_CHK);
  assign chk_entry = is_leaf ? pte_q : pde_q;
  assign req_ready = (state_q == S_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign ev_fault  = in_check && (ev_np || ev_prot);

  xlat_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .dir_frame      (base_q),
    .tbl_frame      (pde_q[VA_W-1:OFF_W]),
    .page_frame     (pte_q[VA_W-1:OFF_W]),
    .vaddr          (va_q),
    .dir_entry_addr (dir_entry_addr),
    .tbl_entry_addr (tbl_entry_addr),
    .phys_addr      (phys_addr)
  );

  xlat_perm_check #(.ENTRY_W(VA_W)) u_perm (
    .entry       (chk_entry),
    .is_write    (wr_q),
    .is_user     (usr_q),
    .is_leaf     (is_leaf),
    .not_present (ev_np),
    .prot_viol   (ev_prot),
    .upd_entry   (upd_entry),
    .need_wb     (need_wb)
  );

  assign mem_req   = (state_q inside {S_DIR_RD, S_DIR_WB, S_TBL_RD, S_TBL_WB});
  assign mem_we    = (state_q == S_DIR_WB) || (state_q == S_TBL_WB);
  assign mem_addr  = is_leaf ? tbl_entry_addr : dir_entry_addr;
  assign mem_wdata = upd_entry;

  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_paddr  = rsp_paddr_q;
  assign rsp_fault  = rsp_fault_q;
  assign rsp_fcode  = rsp_code_q;
  assign fault_addr = fault_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      base_q       <= '0;
      va_q         <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      pde_q        <= '0;
      pte_q        <= '0;
      rsp_paddr_q  <= '0;
      rsp_fault_q  <= 1'b0;
      rsp_code_q   <= '0;
      fault_addr_q <= '0;
    end else begin
      if (base_load) base_q <= base_frame;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_q  <= req_vaddr;
            wr_q  <= req_write;
            usr_q <= req_user;
            if (!xlat_en) begin
              rsp_paddr_q <= req_vaddr;
              rsp_fault_q <= 1'b0;
              rsp_code_q  <= '0;
              state_q     <= S_RESP;
            end else begin
              state_q <= S_DIR_RD;
            end
          end
        end
        S_DIR_RD:   state_q <= S_DIR_WAIT;
        S_DIR_WAIT: begin
          if (mem_rvalid) begin
            pde_q   <= mem_rdata;
            state_q <= S_DIR_CHK;
          end
        end
        S_DIR_CHK: begin
          if (ev_fault) begin
            rsp_fault_q  <= 1'b1;
            rsp_code_q   <= {usr_q, wr_q, ev_prot};
            fault_addr_q <= va_q;
            state_q      <= S_RESP;
          end else if (need_wb) begin
            state_q <= S_DIR_WB;
          end else begin
            state_q <= S_TBL_RD;
          end
        end
        S_DIR_WB:  state_q <= S_DIR_WBW;
        S_DIR_WBW: if (mem_rvalid) state_q <= S_TBL_RD;
        S_TBL_RD:  state_q <= S_TBL_WAIT;
        S_TBL_WAIT: begin
          if (mem_rvalid) begin
            pte_q   <= mem_rdata;
            state_q <= S_TBL_CHK;
          end
        end
        S_TBL_CHK: begin
          if (ev_fault) begin
            rsp_fault_q  <= 1'b1;
            rsp_code_q   <= {usr_q, wr_q, ev_prot};
            fault_addr_q <= va_q;
            state_q      <= S_RESP;
          end else if (need_wb) begin
            state_q <= S_TBL_WB;
          end else begin
            rsp_paddr_q <= phys_addr;
            rsp_fault_q <= 1'b0;
            rsp_code_q  <= '0;
            state_q     <= S_RESP;
          end
        end
        S_TBL_WB: state_q <= S_TBL_WBW;
        S_TBL_WBW: begin
          if (mem_rvalid) begin
            rsp_paddr_q <= phys_addr;
            rsp_fault_q <= 1'b0;
            rsp_code_q  <= '0;
            state_q     <= S_RESP;
          end
        end
        S_RESP:  if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: a strobe is always followed by a wait cycle, never a second access
  p_single_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4: a protection event is only reported for an entry that was present
  p_prot_needs_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && ev_prot) |-> chk_entry[BIT_PRESENT]);

  // R3: any fault found while checking becomes a faulting response next cycle
  p_fault_responds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (rsp_valid && rsp_fault));

  // R6: fault address matches the request being answered
  p_fault_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (fault_addr == va_q));

  // R8: the dirty bit only goes into memory on behalf of a write request
  p_dirty_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && is_leaf && mem_wdata[BIT_DIRTY] && !pte_q[BIT_DIRTY]) |-> wr_q);

  // R9: pass-through answers in the next cycle with the same address
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !xlat_en) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

  // R11: a stalled response holds still
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_fault) && $stable(rsp_fcode)));
endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b1;
  logic        base_load = 1'b0;
  logic [19:0] base_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [2:0]  rsp_fcode;
  logic [31:0] fault_addr;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .base_load(base_load),
    .base_frame(base_frame), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode), .fault_addr(fault_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } op_t;

  logic [31:0] pmem [int unsigned];
  op_t         exp_q[$];
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  string       cur_tag = "R1";
  logic [19:0] model_base = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory: completes every access one cycle after the strobe
  always @(posedge clk) begin
    mem_rvalid <= mem_req && rst_n;
    if (mem_req) begin
      mem_rdata <= rd(mem_addr);
      if (mem_we) pmem[mem_addr] = mem_wdata;
    end
  end

  // every access is compared against the model's expected sequence
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected access", mem_addr, 32'h0);
      end else begin
        op_t op;
        op = exp_q.pop_front();
        chk(mem_we == op.we, cur_tag, "access kind", 32'(mem_we), 32'(op.we));
        chk(mem_addr == op.addr, cur_tag, "access address", mem_addr, op.addr);
        if (op.we) chk(mem_wdata == op.data, cur_tag, "written entry", mem_wdata, op.data);
      end
    end
  end

  // behavioural reference: what the walk must do for this request
  task automatic model(input logic [31:0] va, input bit w, input bit u, input bit en,
                       output logic [31:0] epa, output bit ef, output logic [2:0] ec);
    logic [31:0] da, ta, pde, pte, nv;
    epa = va; ef = 1'b0; ec = 3'b000;
    if (!en) return;
    da  = model_base * 32'd4096 + 32'(va[31:22]) * 32'd4;
    pde = rd(da);
    exp_q.push_back('{1'b0, da, 32'h0});
    if (pde[0] == 1'b0) begin ef = 1'b1; ec = {u, w, 1'b0}; return; end
    if ((w && !pde[1]) || (u && !pde[2])) begin ef = 1'b1; ec = {u, w, 1'b1}; return; end
    if (!pde[5]) exp_q.push_back('{1'b1, da, pde | 32'h20});
    ta  = (pde & 32'hFFFF_F000) + 32'(va[21:12]) * 32'd4;
    pte = rd(ta);
    exp_q.push_back('{1'b0, ta, 32'h0});
    if (pte[0] == 1'b0) begin ef = 1'b1; ec = {u, w, 1'b0}; return; end
    if ((w && !pte[1]) || (u && !pte[2])) begin ef = 1'b1; ec = {u, w, 1'b1}; return; end
    nv = pte | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nv != pte) exp_q.push_back('{1'b1, ta, nv});
    epa = (pte & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
  endtask

  task automatic load_base(input logic [19:0] fr);
    @(negedge clk);
    base_load = 1'b1; base_frame = fr;
    @(negedge clk);
    base_load = 1'b0;
    model_base = fr;
  endtask

  task automatic run(input string tag, input logic [31:0] va, input bit w, input bit u,
                     input bit en, input int stall);
    logic [31:0] epa;
    logic [31:0] held;
    bit          ef;
    logic [2:0]  ec;
    int          n;
    cur_tag = tag;
    model(va, w, u, en, epa, ef, ec);
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready while idle", 32'(req_ready), 32'h1);
    req_vaddr = va; req_write = w; req_user = u; xlat_en = en; req_valid = 1'b1;
    rsp_ready = (stall == 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!en) chk(rsp_valid === 1'b1, "R9", "pass-through latency", 32'(rsp_valid), 32'h1);
    n = 0;
    while (rsp_valid !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(rsp_valid === 1'b1, tag, "response arrived", 32'(rsp_valid), 32'h1);
    chk(rsp_fault === ef, tag, "fault flag", 32'(rsp_fault), 32'(ef));
    if (ef) begin
      chk(rsp_fcode == ec, "R3/R4/R5", "error code", 32'(rsp_fcode), 32'(ec));
      chk(fault_addr == va, "R6", "fault address", fault_addr, va);
    end else begin
      chk(rsp_paddr == epa, tag, "physical address", rsp_paddr, epa);
    end
    held = rsp_paddr;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_paddr == held && req_ready === 1'b0, "R11",
          "held response", rsp_paddr, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11", "response consumed", 32'(rsp_valid), 32'h0);
    chk(exp_q.size() == 0, tag, "missing accesses", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // page structures
    pmem[32'h0005_C3E8] = 32'h0003_F007;  // dir 0x0FA -> table 0x3F000, A clear
    pmem[32'h0003_F0DC] = 32'h0001_B007;  // tbl 0x037 -> frame 0x1B000, A clear
    pmem[32'h0003_F0E4] = 32'h0002_2005;  // tbl 0x039 -> read-only user page
    pmem[32'h0005_C008] = 32'h0004_0003;  // dir 0x002 -> supervisor-only table
    pmem[32'h0006_03E8] = 32'h0003_F027;  // second directory, entry 0x0FA

    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && mem_req === 1'b0, "R11", "reset outputs",
        {30'h0, rsp_valid, mem_req}, 32'h0);
    chk(req_ready === 1'b1, "R11", "reset ready", 32'(req_ready), 32'h1);
    rst_n = 1'b1;
    load_base(20'h0005C);

    // worked example: accessed write-back at both levels
    run("R1/R2/R7", 32'h3E83_7B0A, 1'b0, 1'b0, 1'b1, 0);
    chk(pmem[32'h0005_C3E8] == 32'h0003_F027, "R7", "dir accessed", pmem[32'h0005_C3E8], 32'h0003_F027);
    chk(pmem[32'h0003_F0DC] == 32'h0001_B027, "R7", "tbl accessed", pmem[32'h0003_F0DC], 32'h0001_B027);
    // write: dirty only at the table level
    run("R2/R8", 32'h3E83_7B0A, 1'b1, 1'b0, 1'b1, 0);
    chk(pmem[32'h0003_F0DC] == 32'h0001_B067, "R8", "tbl dirty", pmem[32'h0003_F0DC], 32'h0001_B067);
    chk(pmem[32'h0005_C3E8] == 32'h0003_F027, "R8", "dir untouched", pmem[32'h0005_C3E8], 32'h0003_F027);
    // repeat write with stalled consumer: no write-backs at all
    run("R7/R11", 32'h3E83_7FFF, 1'b1, 1'b0, 1'b1, 3);
    // not present at directory level, user read
    run("R3", 32'h0041_2345, 1'b0, 1'b1, 1'b1, 0);
    // not present at table level, supervisor write
    run("R3", 32'h3E83_8010, 1'b1, 1'b0, 1'b1, 0);
    // read-only user page: user read passes, user write faults
    run("R4", 32'h3E83_9123, 1'b0, 1'b1, 1'b1, 0);
    chk(pmem[32'h0003_F0E4] == 32'h0002_2025, "R8", "read sets no dirty", pmem[32'h0003_F0E4], 32'h0002_2025);
    run("R4/R5", 32'h3E83_9123, 1'b1, 1'b1, 1'b1, 0);
    chk(pmem[32'h0003_F0E4] == 32'h0002_2025, "R8", "fault sets no dirty", pmem[32'h0003_F0E4], 32'h0002_2025);
    // supervisor-only directory: user read faults, supervisor read walks on
    run("R4/R5", 32'h0080_0010, 1'b0, 1'b1, 1'b1, 0);
    run("R3/R7", 32'h0080_0010, 1'b0, 1'b0, 1'b1, 0);
    // pass-through
    run("R9", 32'h1234_5678, 1'b1, 1'b1, 1'b0, 0);
    run("R9/R11", 32'hFFFF_F001, 1'b0, 1'b0, 1'b0, 2);
    // new directory base
    load_base(20'h00060);
    run("R10", 32'h3E83_7B0A, 1'b0, 1'b0, 1'b1, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule